// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer with PWM Output

This block holds a set of independent channels, each built around a down-counter and controlled through 32-bit word registers. A channel runs either as a periodic timer or as a pulse-width generator. In timer mode the counter counts down and raises a status bit each time it expires. In pulse-width mode the channel output alternates between a low phase and a high phase. Each phase takes its length, in clock cycles, from its own load register.

Software sets up a channel while it is stopped: it writes the low-phase count, the high-phase count and the mode bits, then sets the enable bit. Each channel's group of registers repeats at a fixed stride. The high-phase count registers sit apart from these groups, in a table of their own with a four-byte stride. Each channel also has one interrupt line, which software can mask. A read-only version word identifies the block.

Top module: `tmr_pwm_bank`

## Requirements
- R1: Channel k has the following registers: low count at byte address k*0x14, current count (read-only) at k*0x14+0x04, control at k*0x14+0x08, status clear (write-only) at k*0x14+0x0C, and status at k*0x14+0x10 in bit 0. The high count is at 0xB0+k*4. The low count, the high count and the control register read back what was written.
- R2: The control register has four bits: bit 0 enables the channel, bit 1 selects reload from the low count in timer mode, bit 2 masks the interrupt, and bit 3 selects pulse-width mode. Bits 31:4 read as zero.
- R3: In pulse-width mode, a control write that sets enable on a stopped channel starts a cycle. From the clock edge of that write, the output is low for L cycles (L is the low count) and then high for H cycles (H is the high count). The cycle then repeats for as long as the channel stays enabled.
- R4: A control write with bit 0 clear forces the output low from the next cycle. It also freezes the current count.
- R5: A load-count write made while the channel runs does not change the phase in progress. The new value applies from the next reload of that phase.
- R6: In timer mode with reload selected, the status bit sets L cycles after the enable write and again every L cycles after that. The channel output stays low in timer mode.
- R7: In timer mode with reload not selected, the counter loads all ones when enabled. It then decrements by one each cycle, as seen at the current-count register.
- R8: In pulse-width mode, the status bit sets at the end of every high phase. Any write to the channel's clear address resets the status bit, and a set in the same cycle takes priority over the clear.
- R9: The channel's interrupt output is high exactly when its status bit is 1 and its mask bit is 0.
- R10: Address 0xAC reads the version parameter. Any address that is not mapped, and any address not aligned to a word, reads zero.
- R11: Channels are independent. Activity on one channel never changes another channel's output or interrupt.
- R12: A control write that keeps enable set on a channel that is already running does not restart or disturb its counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each count is one period |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | NCH | Per-channel pulse-width outputs |
| irq | output | NCH | Per-channel interrupt, status gated by the mask |

## Verification
A wrong phase flag or a wrong counter shows up on pwm_out within one phase length. The first error appears as a transition that comes early or late, or one that never comes, measured against the cycle of the enable write. A status bit that sets at the wrong time, or fails to clear, shows up on irq in the cycle it goes wrong, because irq has no register after the status bit. Decode errors in the split map appear at once on bus_rdata. They also appear on another channel's output if a write lands on the wrong channel.

// File: rtl/tmr_pwm_bank.sv
module tmr_pwm_bank #(
  parameter int NCH = 4,
  parameter int CW = 32,
  parameter int AW = 8,
  parameter logic [31:0] VERSION = 32'h0001_0203
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic [NCH-1:0]  pwm_out,
  output logic [NCH-1:0]  irq
);
  localparam int STRIDE  = 'h14;
  localparam int O_LD    = 'h00;
  localparam int O_CUR   = 'h04;
  localparam int O_CTL   = 'h08;
  localparam int O_CLR   = 'h0C;
  localparam int O_STS   = 'h10;
  localparam int VER_A   = 'hAC;
  localparam int HI_BASE = 'hB0;
  localparam int HI_STEP = 'h04;

  logic [NCH-1:0][CW-1:0] ld1_a, ld2_a, cnt_a;
  logic [NCH-1:0][3:0]    ctl_a;
  logic [NCH-1:0]         sts_a;
  logic [NCH-1:0]         en_vec;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [AW-1:0] A_LD  = AW'(g*STRIDE + O_LD);
    localparam logic [AW-1:0] A_CTL = AW'(g*STRIDE + O_CTL);
    localparam logic [AW-1:0] A_CLR = AW'(g*STRIDE + O_CLR);
    localparam logic [AW-1:0] A_HI  = AW'(HI_BASE + g*HI_STEP);

    logic [CW-1:0] ld1, ld2, cnt;
    logic [3:0]    ctl;
    logic          hi, sts;

    wire wr_ctl = bus_we && bus_addr == A_CTL;
    wire start  = wr_ctl && bus_wdata[0] && !ctl[0];
    wire stop   = wr_ctl && !bus_wdata[0];
    wire run    = ctl[0] && !stop;
    wire expire = run && cnt <= CW'(1);
    wire pend   = expire && (!ctl[3] || hi);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ld1 <= '0;
        ld2 <= '0;
        cnt <= '0;
        ctl <= '0;
        hi  <= 1'b0;
        sts <= 1'b0;
      end else begin
        if (bus_we && bus_addr == A_LD) ld1 <= bus_wdata[CW-1:0];
        if (bus_we && bus_addr == A_HI) ld2 <= bus_wdata[CW-1:0];
        if (wr_ctl) ctl <= bus_wdata[3:0];
        if (pend) sts <= 1'b1;
        else if (bus_we && bus_addr == A_CLR) sts <= 1'b0;
        if (start) begin
          cnt <= (bus_wdata[3] || bus_wdata[1]) ? ld1 : '1;
          hi  <= 1'b0;
        end else if (stop) begin
          hi  <= 1'b0;
        end else if (run) begin
          if (!expire) cnt <= cnt - CW'(1);
          else if (ctl[3]) begin
            cnt <= hi ? ld1 : ld2;
            hi  <= !hi;
          end else cnt <= ctl[1] ? ld1 : '1;
        end
      end
    end

    assign ld1_a[g]   = ld1;
    assign ld2_a[g]   = ld2;
    assign cnt_a[g]   = cnt;
    assign ctl_a[g]   = ctl;
    assign sts_a[g]   = sts;
    assign en_vec[g]  = ctl[0];
    assign pwm_out[g] = ctl[0] && ctl[3] && hi;
    assign irq[g]     = sts && !ctl[2];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(VER_A)) bus_rdata = VERSION;
    for (int k = 0; k < NCH; k++) begin
      if (bus_addr == AW'(k*STRIDE + O_LD))  bus_rdata[CW-1:0] = ld1_a[k];
      if (bus_addr == AW'(k*STRIDE + O_CUR)) bus_rdata[CW-1:0] = cnt_a[k];
      if (bus_addr == AW'(k*STRIDE + O_CTL)) bus_rdata[3:0]    = ctl_a[k];
      if (bus_addr == AW'(k*STRIDE + O_STS)) bus_rdata[0]      = sts_a[k];
      if (bus_addr == AW'(HI_BASE + k*HI_STEP)) bus_rdata[CW-1:0] = ld2_a[k];
    end
  end
endmodule

// File: rtl/tmr_pwm_bank_chk.sv
module tmr_pwm_bank_chk #(
  parameter int NCH = 4,
  parameter int AW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_we,
  input logic [AW-1:0]  bus_addr,
  input logic [31:0]    bus_wdata,
  input logic [31:0]    bus_rdata,
  input logic [NCH-1:0] pwm_out,
  input logic [NCH-1:0] irq,
  input logic [NCH-1:0] en_vec
);
  p_misaligned_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[1:0] != 2'b00) |-> (bus_rdata == 32'd0));

  for (genvar k = 0; k < NCH; k++) begin : g_chk
    localparam logic [AW-1:0] A_CTL = AW'(k*'h14 + 'h08);
    wire ctl_wr = bus_we && bus_addr == A_CTL;

    p_stop_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !bus_wdata[0]) |=> !pwm_out[k]);

    p_mask_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && bus_wdata[2]) |=> !irq[k]);

    p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && bus_wdata[0] && !en_vec[k]) |=> (en_vec[k] && !pwm_out[k]));

    p_rise_needs_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_out[k]) |-> $past(en_vec[k]));
  end
endmodule

bind tmr_pwm_bank tmr_pwm_bank_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out),
  .irq(irq), .en_vec(en_vec)
);

// File: tb/test_tmr_pwm_bank.sv
module test_tmr_pwm_bank;
  localparam int NCH = 4;
  localparam int AW = 8;
  localparam logic [31:0] VER = 32'h0001_0203;

  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NCH-1:0] pwm_out, irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmr_pwm_bank #(.NCH(NCH), .AW(AW), .VERSION(VER)) i_tmr_pwm_bank (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out), .irq(irq));

  function automatic int a_ld1(int k); return k*'h14; endfunction
  function automatic int a_cur(int k); return k*'h14 + 4; endfunction
  function automatic int a_ctl(int k); return k*'h14 + 8; endfunction
  function automatic int a_clr(int k); return k*'h14 + 'hC; endfunction
  function automatic int a_sts(int k); return k*'h14 + 'h10; endfunction
  function automatic int a_ld2(int k); return 'hB0 + k*4; endfunction

  function automatic bit exp_hi(int n, int a1, int a2, int b1, int b2);
    if (n < a1 + a2) return n >= a1;
    return ((n - a1 - a2) % (b1 + b2)) >= b1;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    bus_addr = AW'(a); #1; d = bus_rdata;
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk(pwm_out == 0 && irq == 0, "reset outputs", {pwm_out, irq}, 0);
    rd(a_ctl(2), v); chk(v == 0, "R2 reset ctrl", v, 0);
    rd('hAC, v); chk(v == VER, "R10 version", v, VER);
    rd('hAD, v); chk(v == 0, "R10 misaligned", v, 0);
    rd('hA0, v); chk(v == 0, "R10 unmapped", v, 0);

    for (int k = 0; k < NCH; k++) begin
      wr(a_ld1(k), 32'h100 + k);
      wr(a_ld2(k), 32'h200 + k);
    end
    for (int k = 0; k < NCH; k++) begin
      rd(a_ld1(k), v); chk(v == 32'h100 + k, "R1 low count", v, 32'h100 + k);
      rd(a_ld2(k), v); chk(v == 32'h200 + k, "R1 high count", v, 32'h200 + k);
    end
    wr(a_ctl(1), 32'hFFFF_FFFE);
    rd(a_ctl(1), v); chk(v == 32'hE, "R2 ctrl bits", v, 32'hE);
    chk(pwm_out == 0, "R11 no output", pwm_out, 0);
    wr(a_ctl(1), 0);

    for (int it = 0; it < 8; it++) begin
      int ch = $urandom % NCH;
      int l1 = 2 + $urandom % 8;
      int l2 = 2 + $urandom % 8;
      int per = l1 + l2;
      wr(a_ld1(ch), l1); wr(a_ld2(ch), l2);
      wr(a_ctl(ch), 32'h9);
      for (int n = 0; n < 2*per + 3; n++) begin
        if (n == 3) begin
          wr(a_ctl(ch), 32'h9);
          n++;
        end
        chk(pwm_out[ch] == exp_hi(n, l1, l2, l1, l2), "R3 pwm pattern (R12 rewrite)",
            pwm_out[ch], exp_hi(n, l1, l2, l1, l2));
        chk(irq[ch] == (n >= per), "R8 period status", irq[ch], n >= per);
        chk((pwm_out & ~(NCH'(1) << ch)) == 0 && (irq & ~(NCH'(1) << ch)) == 0,
            "R11 other channels", {pwm_out, irq}, 0);
        @(negedge clk);
      end
      wr(a_ctl(ch), 32'h8);
      chk(pwm_out[ch] == 0, "R4 stop forces low", pwm_out[ch], 0);
      rd(a_cur(ch), v); @(negedge clk); @(negedge clk); rd(a_cur(ch), v2);
      chk(v == v2, "R4 count frozen", v2, v);
      wr(a_clr(ch), 0);
      chk(irq[ch] == 0, "R8 clear", irq[ch], 0);
    end

    wr(a_ld1(0), 4); wr(a_ld2(0), 3);
    wr(a_ctl(0), 32'h9);
    wr(a_ld1(0), 6);
    for (int n = 1; n < 30; n++) begin
      chk(pwm_out[0] == exp_hi(n, 4, 3, 6, 3), "R5 deferred load", pwm_out[0],
          exp_hi(n, 4, 3, 6, 3));
      @(negedge clk);
    end
    wr(a_ctl(0), 0); wr(a_clr(0), 0);

    wr(a_ld1(2), 5);
    wr(a_ctl(2), 32'h3);
    for (int n = 0; n < 14; n++) begin
      if (n == 6) begin
        wr(a_clr(2), 0);
        n++;
      end
      chk(irq[2] == ((n >= 5 && n < 7) || n >= 10), "R6 timer expiry", irq[2],
          (n >= 5 && n < 7) || n >= 10);
      chk(pwm_out[2] == 0, "R6 no timer output", pwm_out[2], 0);
      @(negedge clk);
    end
    wr(a_ctl(2), 32'h7);
    chk(irq[2] == 0, "R9 masked", irq[2], 0);
    rd(a_sts(2), v); chk(v == 1, "R8 status readable", v, 1);
    wr(a_ctl(2), 32'h3);
    chk(irq[2] == 1, "R9 unmasked", irq[2], 1);
    wr(a_ctl(2), 0); wr(a_clr(2), 0);

    wr(a_ctl(3), 32'h1);
    for (int n = 0; n < 5; n++) begin
      rd(a_cur(3), v);
      chk(v == 32'hFFFF_FFFF - n, "R7 free running", v, 32'hFFFF_FFFF - n);
      @(negedge clk);
    end
    wr(a_ctl(3), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule